// File: doc/BRIEF.md
# Indexed NVRAM Access Port

This block lets a byte-wide I/O bus reach a nonvolatile memory array with 16-bit addresses through a four-offset register window. Two offsets load the low and the high byte of an internal address pointer. A third offset is the data port, and it moves one byte between the bus and the memory location the pointer names. After every data-port write the pointer returns to zero, so each new transfer starts by loading an address.

The block drives a simple synchronous memory. Address, write data and write enable go out in the cycle of the bus write. Read data comes back one clock after the address is presented. Two fixed 16-byte regions can be protected by a two-bit lock register. Each lock bit is flipped by a pulse on a toggle input, with an index that picks the bit. A protected location, or one beyond the configured memory size, takes no write and reads as all ones.

Top module: `nvram_index_port`

## Requirements
- R1: A bus write to offset 0 replaces bits 7:0 of the address pointer and leaves bits 15:8 unchanged. The pointer is visible on `mem_addr` from the next cycle.
- R2: A bus write to offset 1 replaces bits 15:8 of the address pointer and leaves bits 7:0 unchanged.
- R3: A bus write to offset 3 raises `mem_we` in the same cycle, with `mem_addr` equal to the pointer and `mem_wdata` equal to the bus byte, when the target is permitted.
- R4: After any bus write to offset 3 the pointer is zero, whether or not the memory write was permitted.
- R5: A bus read asserts `bus_rvalid` in the next cycle. For offset 3 with a permitted pointer, `bus_rdata` then holds the stored byte. A read never changes the pointer.
- R6: A read of offset 0, 1 or 2 returns 0xFF.
- R7: A bus write to offset 2 changes neither the pointer nor the memory (`mem_we` stays low).
- R8: While lock bit 0 is set, addresses 0x20 to 0x2F are protected. While lock bit 1 is set, addresses 0x30 to 0x3F are protected. A write to a protected address leaves `mem_we` low, and a read of it returns 0xFF.
- R9: A pulse on `lock_flip` inverts the lock bit selected by `lock_idx`. An access in the same cycle is judged against the lock state from before the flip.
- R10: A pointer at or above MEM_SIZE gives no memory write and reads back 0xFF.
- R11: Reset clears the pointer, both lock bits and `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Port offset of the bus access |
| bus_wr | input | 1 | Bus write strobe, one cycle per byte |
| bus_rd | input | 1 | Bus read strobe, one cycle per byte |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| lock_flip | input | 1 | Pulse that inverts one lock bit |
| lock_idx | input | 1 | Index of the lock bit to invert |
| mem_addr | output | 16 | Memory address (the pointer) |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_addr |

## Verification
A lock toggle and a data-port access can land in the same clock. In that case the access must use the lock state from before the toggle. The bench makes this happen by pulsing `lock_flip` in the same cycle as a data-port read of a window address, and again in the same cycle as a data-port write. It then expects the read to follow the old lock bit and the write enable to follow the old lock bit. A second access right afterwards must show the new lock state.

// File: rtl/nvram_ix_pkg.sv
package nvram_ix_pkg;
    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] OFS_PTR_LO = 2'd0;
    localparam logic [1:0] OFS_PTR_HI = 2'd1;
    localparam logic [1:0] OFS_DATA   = 2'd3;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             rvalid;
        logic             ones;
    } port_state_t;
endpackage

// File: rtl/nvram_lock_ctl.sv
module nvram_lock_ctl #(
    parameter int N_LOCK    = 2,
    parameter int WIN_BASE  = 32,
    parameter int WIN_SPAN  = 16,
    parameter int IDX_W     = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flip,
    input  logic [IDX_W-1:0]               idx,
    input  logic [nvram_ix_pkg::PTR_W-1:0] addr,
    output logic                           blocked
);
    import nvram_ix_pkg::*;

    logic [N_LOCK-1:0] lock_d, lock_q;
    logic [N_LOCK-1:0] hit;

    always_comb begin
        lock_d = lock_q;
        for (int i = 0; i < N_LOCK; i++) begin
            if (flip && (int'(idx) == i)) lock_d[i] = ~lock_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    for (genvar g = 0; g < N_LOCK; g++) begin : g_win
        localparam logic [PTR_W:0] LO = (PTR_W+1)'(WIN_BASE + g * WIN_SPAN);
        localparam logic [PTR_W:0] HI = (PTR_W+1)'(WIN_BASE + (g + 1) * WIN_SPAN);
        assign hit[g] = lock_q[g] && ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end

    assign blocked = |hit;

    // R9: a flip inverts exactly the selected bit
    p_flip_inverts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && int'(idx) < N_LOCK) |=> (lock_q[$past(idx)] != $past(lock_q[idx])));

    // R9: with no flip, the lock bits hold
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flip |=> $stable(lock_q));
endmodule

// File: rtl/nvram_access_gate.sv
module nvram_access_gate #(
    parameter int MEM_SIZE = 2048
) (
    input  logic [nvram_ix_pkg::PTR_W-1:0] addr,
    input  logic                           blocked,
    output logic                           ok
);
    import nvram_ix_pkg::*;

    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(MEM_SIZE);

    logic in_range;

    always_comb begin
        in_range = ({1'b0, addr} < LIMIT);
        ok       = in_range && !blocked;
    end
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port #(
    parameter int MEM_SIZE = 2048,
    parameter int N_LOCK   = 2,
    parameter int WIN_BASE = 32,
    parameter int WIN_SPAN = 16,
    localparam int IDX_W   = (N_LOCK > 1) ? $clog2(N_LOCK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             bus_rvalid,
    input  logic             lock_flip,
    input  logic [IDX_W-1:0] lock_idx,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    input  logic [7:0]       mem_rdata
);
    import nvram_ix_pkg::*;

    port_state_t st_d, st_q;
    logic        blocked;
    logic        ok;
    logic        data_wr;

    nvram_lock_ctl #(
        .N_LOCK  (N_LOCK),
        .WIN_BASE(WIN_BASE),
        .WIN_SPAN(WIN_SPAN),
        .IDX_W   (IDX_W)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip   (lock_flip),
        .idx    (lock_idx),
        .addr   (st_q.ptr),
        .blocked(blocked)
    );

    nvram_access_gate #(
        .MEM_SIZE(MEM_SIZE)
    ) u_gate (
        .addr   (st_q.ptr),
        .blocked(blocked),
        .ok     (ok)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_rd;
        if (bus_rd) st_d.ones = (bus_sel != OFS_DATA) || !ok;
        if (bus_wr) begin
            case (bus_sel)
                OFS_PTR_LO: st_d.ptr[7:0]       = bus_wdata;
                OFS_PTR_HI: st_d.ptr[PTR_W-1:8] = bus_wdata;
                OFS_DATA:   st_d.ptr            = '0;
                default:    ;
            endcase
        end
        data_wr = bus_wr && (bus_sel == OFS_DATA);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr   = st_q.ptr;
    assign mem_wdata  = bus_wdata;
    assign mem_we     = data_wr && ok;
    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.ones ? 8'hFF : mem_rdata;

    // R4: a data-port write always leaves the pointer at zero
    p_clear_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == OFS_DATA) |=> (mem_addr == '0));

    // R5: a read alone never moves the pointer
    p_read_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> $stable(mem_addr));

    // R5: a read is answered in the next cycle
    p_rvalid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R7: offset 2 writes change nothing
    p_ofs2_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2) |-> !mem_we);

    // R8: a protected location is never written
    p_lock_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !mem_we);

    // R10: memory writes stay inside the array
    p_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < MEM_SIZE));
endmodule

// File: tb/tb_nvram_index_port.sv
module tb_nvram_index_port;
    localparam int MSZ = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic       lock_flip = 1'b0;
    logic [0:0] lock_idx = '0;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;

    logic [7:0] mem_arr [MSZ];
    logic [7:0] shadow  [MSZ];
    logic [1:0] lk;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nvram_index_port #(.MEM_SIZE(MSZ)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .lock_flip(lock_flip), .lock_idx(lock_idx), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we && int'(mem_addr) < MSZ) mem_arr[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= (int'(mem_addr) < MSZ) ? mem_arr[mem_addr[7:0]] : 8'h00;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [1:0] s, input logic [7:0] d,
                       input logic f, input logic fi,
                       output logic we, output logic [7:0] rd, output logic rv);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_sel = s; bus_wdata = d; lock_flip = f; lock_idx = fi;
        #1 we = mem_we;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; lock_flip = 0;
        rd = bus_rdata; rv = bus_rvalid;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        logic we; logic [7:0] rd; logic rv;
        cyc(1, 0, 2'd0, a[7:0], 0, 0, we, rd, rv);
        cyc(1, 0, 2'd1, a[15:8], 0, 0, we, rd, rv);
    endtask

    function automatic logic permitted(input int a);
        if (a >= MSZ) return 0;
        if (lk[0] && a >= 32 && a < 48) return 0;
        if (lk[1] && a >= 48 && a < 64) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        return permitted(a) ? shadow[a[7:0]] : 8'hFF;
    endfunction

    task automatic wr_at(input int a, input logic [7:0] v, input string tag);
        logic we; logic [7:0] rd; logic rv;
        set_ptr(16'(a));
        cyc(1, 0, 2'd3, v, 0, 0, we, rd, rv);
        chk({tag, " we"}, 16'(we), 16'(permitted(a)));
        chk("R4 ptr cleared", mem_addr, 16'h0);
        if (permitted(a)) shadow[a[7:0]] = v;
    endtask

    task automatic rd_at(input int a, input string tag);
        logic we; logic [7:0] rd; logic rv;
        set_ptr(16'(a));
        cyc(0, 1, 2'd3, 8'h00, 0, 0, we, rd, rv);
        chk({tag, " data"}, 16'(rd), 16'(exp_rd(a)));
        chk("R5 rvalid", 16'(rv), 16'h1);
        chk("R5 ptr kept", mem_addr, 16'(a));
    endtask

    initial begin
        logic we; logic [7:0] rd; logic rv;
        for (int i = 0; i < MSZ; i++) begin mem_arr[i] = 8'h00; shadow[i] = 8'h00; end
        lk = 2'b00;
        repeat (3) @(negedge clk);
        chk("R11 reset ptr", mem_addr, 16'h0);
        chk("R11 reset rvalid", 16'(bus_rvalid), 16'h0);
        rst_n = 1'b1;

        // pointer byte loads
        cyc(1, 0, 2'd0, 8'h5A, 0, 0, we, rd, rv);
        chk("R1 low byte", mem_addr, 16'h005A);
        cyc(1, 0, 2'd1, 8'hC3, 0, 0, we, rd, rv);
        chk("R2 high byte", mem_addr, 16'hC35A);
        cyc(1, 0, 2'd0, 8'h11, 0, 0, we, rd, rv);
        chk("R1 keeps high", mem_addr, 16'hC311);
        cyc(1, 0, 2'd2, 8'h77, 0, 0, we, rd, rv);
        chk("R7 ptr unchanged", mem_addr, 16'hC311);
        chk("R7 no write", 16'(we), 16'h0);

        // write sweep across the array
        for (int a = 0; a < MSZ; a++) wr_at(a, 8'((a * 37 + 11) & 255), "R3 write");
        for (int a = 0; a < MSZ; a++) rd_at(a, "R5 read");

        // non-data offsets read as ones
        for (int s = 0; s < 3; s++) begin
            set_ptr(16'h0010);
            cyc(0, 1, 2'(s), 8'h00, 0, 0, we, rd, rv);
            chk("R6 other offset", 16'(rd), 16'h00FF);
        end

        // out of range
        wr_at(256, 8'hAA, "R10 write");
        wr_at(65535, 8'hAB, "R10 write");
        wr_at(16'h1234, 8'hAC, "R10 write");
        rd_at(256, "R10 read");
        rd_at(65535, "R10 read");

        // lock windows
        cyc(0, 0, 2'd0, 8'h00, 1, 0, we, rd, rv); lk[0] = ~lk[0];
        for (int a = 28; a < 68; a++) wr_at(a, 8'(a ^ 8'h5C), "R8 lock0 write");
        for (int a = 28; a < 68; a++) rd_at(a, "R8 lock0 read");
        cyc(0, 0, 2'd0, 8'h00, 1, 1, we, rd, rv); lk[1] = ~lk[1];
        for (int a = 28; a < 68; a++) wr_at(a, 8'(a ^ 8'hA3), "R8 both write");
        for (int a = 28; a < 68; a++) rd_at(a, "R8 both read");
        cyc(0, 0, 2'd0, 8'h00, 1, 0, we, rd, rv); lk[0] = ~lk[0];
        for (int a = 28; a < 68; a++) rd_at(a, "R9 toggle back read");

        // same-cycle flip and access: old lock state decides (lk = 2'b10)
        set_ptr(16'h0035);
        cyc(0, 1, 2'd3, 8'h00, 1, 1, we, rd, rv);
        chk("R9 read uses old lock", 16'(rd), 16'h00FF);
        lk[1] = 1'b0;
        rd_at(16'h0035, "R9 read after flip");
        set_ptr(16'h0024);
        cyc(1, 0, 2'd3, 8'h9E, 1, 0, we, rd, rv);
        chk("R9 write uses old lock", 16'(we), 16'h1);
        shadow[8'h24] = 8'h9E;
        lk[0] = 1'b1;
        rd_at(16'h0024, "R9 read now locked");

        // reset mid-run clears locks and pointer
        set_ptr(16'h0042);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        lk = 2'b00;
        chk("R11 ptr after reset", mem_addr, 16'h0);
        rd_at(16'h0024, "R11 locks cleared");
        rd_at(16'h0035, "R11 locks cleared");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule